// File: doc/BRIEF.md
# Serial Byte Receiver with Command/Data Tag

This block is the receive side of a four-wire serial link into a display controller. An external master drives a serial clock, a data line, an active-low select and a sideband line that marks each byte as a command or as display data. While select is low, the block shifts in one bit on every rising serial-clock edge. After every eighth bit it moves the completed byte, together with its tag, into the system clock domain. There it appears on a byte output with a flag and a strobe that lasts one cycle.

Raising select holds the bit counter and the shift register in reset. A byte left incomplete at that moment is lost. Completed bytes cross clock domains through a toggle handshake, so the system side never samples a byte while it is changing. Command decoding and display-memory writes are handled by logic downstream.

Top module: `dispctl_spi_rx`

## Requirements
- R1: After system reset, `rx_byte` is 0, `rx_is_data` is 0 and `rx_strobe` is 0.
- R2: With the default `MSB_FIRST` = 1, the first bit sampled after select falls becomes bit 7 of the delivered byte, and the eighth bit becomes bit 0.
- R3: `rx_is_data` is 0 when `spi_dc` was low (command) and 1 when `spi_dc` was high (display data).
- R4: `spi_dc` is sampled only on the eighth rising `spi_sclk` edge of a byte. Its level on the seven earlier edges has no effect.
- R5: If `spi_cs_n` rises before the eighth edge, the partial byte produces no strobe. The next byte is assembled from its own first bit onward.
- R6: Several bytes sent back to back under one low period of select are each delivered, in order.
- R7: Each completed byte raises `rx_strobe` for exactly one system clock cycle.
- R8: `rx_byte` and `rx_is_data` change only in the cycle in which `rx_strobe` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| spi_cs_n | input | 1 | Active-low select; high resets the shift logic |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_sdin | input | 1 | Serial data, sampled on the rising edge of `spi_sclk` |
| spi_dc | input | 1 | Tag line: 0 marks a command, 1 marks display data |
| rx_byte | output | DATA_W | Last received byte |
| rx_is_data | output | 1 | Tag of `rx_byte`: 1 means display data |
| rx_strobe | output | 1 | One-cycle pulse when a new byte is presented |

## Verification
If the bit counter drifts, the bytes that follow show up as rotated values. A counter left over from an aborted transfer shows up in the very next byte, so the effect is visible at the first strobe after the fault. If the tag is sampled on the wrong edge, `rx_is_data` disagrees with the level on the final edge. The test that drives a different tag level on the earlier edges reveals this on the first byte of that test. A broken handshake shows up within a few system cycles of the eighth edge. It appears either as a missing strobe, as a strobe lasting two cycles, or as data that changes with no strobe.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

   typedef struct packed {
      logic [7:0] data;
      logic       is_data;
   } dsr_word_t;

   function automatic int unsigned dsr_cnt_w(input int unsigned w);
      return (w <= 2) ? 1 : $clog2(w);
   endfunction

endpackage

// File: rtl/dsr_shifter.sv
module dsr_shifter #(
   parameter int unsigned DATA_W    = 8,
   parameter bit          MSB_FIRST = 1'b1,
   localparam int unsigned CNT_W    = dsr_pkg::dsr_cnt_w(DATA_W)
) (
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sclk,
   input  logic              sdin,
   input  logic              dc,
   output logic [DATA_W-1:0] hold_byte,
   output logic              hold_dc,
   output logic              done_tog,
   output logic [CNT_W-1:0]  bit_cnt
);

   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

   logic [DATA_W-1:0] shreg;
   logic [DATA_W-1:0] next_shreg;
   logic              last_edge;

   assign last_edge = (bit_cnt == LAST_BIT);

   generate
      if (MSB_FIRST) begin : g_msb
         assign next_shreg = {shreg[DATA_W-2:0], sdin};
      end else begin : g_lsb
         assign next_shreg = {sdin, shreg[DATA_W-1:1]};
      end
   endgenerate

   // select high clears the partial byte
   always_ff @(posedge sclk or posedge cs_n) begin
      if (cs_n) begin
         shreg   <= '0;
         bit_cnt <= '0;
      end else begin
         shreg   <= next_shreg;
         bit_cnt <= last_edge ? '0 : bit_cnt + 1'b1;
      end
   end

   // completed-byte holding stage survives select going high
   always_ff @(posedge sclk or negedge rst_n) begin
      if (!rst_n) begin
         hold_byte <= '0;
         hold_dc   <= 1'b0;
         done_tog  <= 1'b0;
      end else if (!cs_n && last_edge) begin
         hold_byte <= next_shreg;
         hold_dc   <= dc;
         done_tog  <= ~done_tog;
      end
   end

endmodule

// File: rtl/dsr_sync.sv
module dsr_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      chain[s] <= 1'b0;
            else if (s == 0) chain[s] <= d;
            else             chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/dsr_deliver.sv
module dsr_deliver #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tog_sync,
   input  logic [DATA_W-1:0] hold_byte,
   input  logic              hold_dc,
   output logic [DATA_W-1:0] out_byte,
   output logic              out_dc,
   output logic              out_stb
);

   logic seen_tog;
   logic fresh;

   assign fresh = tog_sync ^ seen_tog;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_tog <= 1'b0;
         out_byte <= '0;
         out_dc   <= 1'b0;
         out_stb  <= 1'b0;
      end else begin
         seen_tog <= tog_sync;
         out_stb  <= fresh;
         if (fresh) begin
            out_byte <= hold_byte;
            out_dc   <= hold_dc;
         end
      end
   end

endmodule

// File: rtl/dispctl_spi_rx.sv
module dispctl_spi_rx #(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          MSB_FIRST   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_cs_n,
   input  logic              spi_sclk,
   input  logic              spi_sdin,
   input  logic              spi_dc,
   output logic [DATA_W-1:0] rx_byte,
   output logic              rx_is_data,
   output logic              rx_strobe
);

   localparam int unsigned CNT_W = dsr_pkg::dsr_cnt_w(DATA_W);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("dispctl_spi_rx: DATA_W must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("dispctl_spi_rx: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] hold_byte;
   logic              hold_dc;
   logic              done_tog;
   logic              tog_sync;
   logic [CNT_W-1:0]  bit_cnt;

   dsr_shifter #(.DATA_W(DATA_W), .MSB_FIRST(MSB_FIRST)) u_shift (
      .rst_n    (rst_n),
      .cs_n     (spi_cs_n),
      .sclk     (spi_sclk),
      .sdin     (spi_sdin),
      .dc       (spi_dc),
      .hold_byte(hold_byte),
      .hold_dc  (hold_dc),
      .done_tog (done_tog),
      .bit_cnt  (bit_cnt)
   );

   dsr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (done_tog),
      .q    (tog_sync)
   );

   dsr_deliver #(.DATA_W(DATA_W)) u_deliver (
      .clk      (clk),
      .rst_n    (rst_n),
      .tog_sync (tog_sync),
      .hold_byte(hold_byte),
      .hold_dc  (hold_dc),
      .out_byte (rx_byte),
      .out_dc   (rx_is_data),
      .out_stb  (rx_strobe)
   );

endmodule

// File: rtl/dispctl_spi_rx_chk.sv
module dispctl_spi_rx_chk #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned CNT_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              spi_cs_n,
   input logic              spi_sclk,
   input logic [DATA_W-1:0] rx_byte,
   input logic              rx_is_data,
   input logic              rx_strobe,
   input logic [CNT_W-1:0]  bit_cnt,
   input logic              done_tog,
   input logic [DATA_W-1:0] hold_byte
);

   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

   // R7: a strobe never lasts two cycles
   assert_single_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_strobe |=> !rx_strobe);

   // R8: outputs hold while no strobe is issued
   assert_hold_outputs_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_strobe |-> ($stable(rx_byte) && $stable(rx_is_data)));

   // R5: completion toggles only on the last bit position
   assert_toggle_at_end_R5: assert property (@(posedge spi_sclk) disable iff (!rst_n || spi_cs_n)
      (bit_cnt != LAST_BIT) |=> $stable(done_tog));

   // R8: holding stage is untouched unless a byte completes
   assert_hold_stage_R8: assert property (@(posedge spi_sclk) disable iff (!rst_n || spi_cs_n)
      $stable(done_tog) |-> $stable(hold_byte));

endmodule

bind dispctl_spi_rx dispctl_spi_rx_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .spi_cs_n  (spi_cs_n),
   .spi_sclk  (spi_sclk),
   .rx_byte   (rx_byte),
   .rx_is_data(rx_is_data),
   .rx_strobe (rx_strobe),
   .bit_cnt   (bit_cnt),
   .done_tog  (done_tog),
   .hold_byte (hold_byte)
);

// File: tb/dispctl_spi_rx_test.sv
`timescale 1ns/1ps
module dispctl_spi_rx_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       spi_cs_n = 1'b1;
   logic       spi_sclk = 1'b0;
   logic       spi_sdin = 1'b0;
   logic       spi_dc = 1'b0;
   logic [7:0] rx_byte;
   logic       rx_is_data;
   logic       rx_strobe;

   int checks = 0;
   int fails  = 0;
   int got    = 0;
   int sent   = 0;
   bit done   = 1'b0;
   logic [8:0] expq[$];

   always #5 clk = ~clk;

   dispctl_spi_rx uut (
      .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
      .spi_sdin(spi_sdin), .spi_dc(spi_dc), .rx_byte(rx_byte),
      .rx_is_data(rx_is_data), .rx_strobe(rx_strobe)
   );

   // strobe monitor: R2 R3 R6 R7 (a two-cycle strobe pops an extra entry)
   always @(negedge clk) begin
      if (rst_n && rx_strobe && !done) begin
         checks++;
         got++;
         if (expq.size() == 0) begin
            fails++;
            $display("FAIL R7: unexpected strobe, got %h/%0b expected none", rx_byte, rx_is_data);
         end else begin
            logic [8:0] e;
            e = expq.pop_front();
            if ({rx_is_data, rx_byte} !== e) begin
               fails++;
               $display("FAIL R2/R3/R6: got byte %h flag %0b expected byte %h flag %0b",
                        rx_byte, rx_is_data, e[7:0], e[8]);
            end
         end
      end
   end

   // nbits bits MSB first; tag level dc_early on earlier edges, dc_last on the eighth
   task automatic spi_bits(input logic [7:0] b, input int nbits,
                           input logic dc_early, input logic dc_last);
      for (int i = 0; i < nbits; i++) begin
         spi_sclk = 1'b0;
         spi_sdin = b[7-i];
         spi_dc   = (i == 7) ? dc_last : dc_early;
         #40;
         spi_sclk = 1'b1;
         #40;
      end
      spi_sclk = 1'b0;
      #40;
   endtask

   task automatic send(input logic [7:0] b, input logic dc_early, input logic dc_last);
      expq.push_back({dc_last, b});
      sent++;
      spi_bits(b, 8, dc_early, dc_last);
   endtask

   task automatic cs(input logic v);
      spi_cs_n = v;
      #100;
   endtask

   task automatic drain;
      repeat (20) @(posedge clk);
      @(negedge clk);
      checks++;
      if (expq.size() != 0) begin
         fails++;
         $display("FAIL R5/R6: %0d bytes not delivered, expected 0", expq.size());
         expq.delete();
      end
   endtask

   initial begin
      #3_000_000;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (5) @(posedge clk);
      @(negedge clk);
      checks++;
      if (rx_byte !== 8'h00 || rx_is_data !== 1'b0 || rx_strobe !== 1'b0) begin
         fails++;
         $display("FAIL R1: reset outputs %h/%0b/%0b expected 00/0/0", rx_byte, rx_is_data, rx_strobe);
      end
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      checks++;
      if (rx_byte !== 8'h00 || rx_strobe !== 1'b0) begin
         fails++;
         $display("FAIL R1: idle outputs %h/%0b expected 00/0", rx_byte, rx_strobe);
      end

      // R2 R3 R6: all byte values, four per select window
      for (int v = 0; v < 256; v++) begin
         logic [7:0] b;
         logic       t;
         b = 8'(v);
         t = b[0] ^ b[3];
         if (v % 4 == 0) cs(1'b0);
         send(b, t, t);
         if (v % 4 == 3) cs(1'b1);
      end
      drain();

      // R4: tag level on the seven earlier edges is ignored
      cs(1'b0);
      send(8'hA5, 1'b1, 1'b0);
      send(8'h5A, 1'b0, 1'b1);
      cs(1'b1);
      drain();

      // R5: partial byte discarded, next byte assembled from scratch
      for (int n = 1; n < 8; n++) begin
         cs(1'b0);
         spi_bits(8'hFF, n, 1'b1, 1'b1);
         cs(1'b1);
         cs(1'b0);
         send(8'(8'h30 + n), 1'b0, 1'b0);
         cs(1'b1);
      end
      drain();

      // R7 R8: total strobes equals bytes sent
      checks++;
      if (got != sent) begin
         fails++;
         $display("FAIL R7: strobe count %0d expected %0d", got, sent);
      end
      // R8: last byte still presented after idle time
      repeat (50) @(negedge clk);
      checks++;
      if (rx_byte !== 8'h37 || rx_is_data !== 1'b0) begin
         fails++;
         $display("FAIL R8: held output %h/%0b expected 37/0", rx_byte, rx_is_data);
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule